// File: doc/BRIEF.md
# CRC-4 Multiframe Overhead Collector

This block sits behind an external CRC-4 multiframe aligner on the receive side of an E1 framer. In each frame the aligner presents the eight timeslot-0 bits together with a frame strobe. It also says whether the frame carries the frame alignment word, and it marks the first frame of every 16-frame multiframe. Over one multiframe the collector gathers the international (Si) bit, the remote-alarm bit and the five national (Sa4 to Sa8) bits into eight byte-wide shift stages. Each stage takes one bit per relevant frame, and the earliest bit ends up in the most significant position.

When the next multiframe begins, the eight completed stages are copied together into host-visible registers and a one-cycle ready pulse is raised. The host then has one full multiframe (2 ms) to read the snapshot before the next copy replaces it. A boundary that arrives before a stage has seen eight samples drops the partial data. Frames seen before the first boundary after reset are also dropped. The host reads the registers through a 3-bit index whose values equal the low three bits of register offsets 0x58 to 0x5F.

Top module: `mfoh_collector`

## Requirements
- R1: After a synchronous reset, `mf_ready` is 0 and all eight host registers read as zero.
- R2: Register index 0 collects bit 7 of `ts0_in` (Si) from align frames only (`frm_align`=1). The first sample of the multiframe lands in bit 7 of the register and the eighth lands in bit 0.
- R3: Indices 1 to 7 sample only from non-align frames (`frm_align`=0). Index 1 takes `ts0_in` bit 7 (Si), index 2 takes bit 5 (remote alarm), and indices 3, 4, 5, 6 and 7 take bits 4, 3, 2, 1 and 0 (Sa4, Sa5, Sa6, Sa7, Sa8). Each register is ordered with the earliest sample in its MSB.
- R4: `rd_data` shows the host register selected by `rd_idx` in the same cycle. The order is 0 Si-align, 1 Si-non-align, 2 remote alarm, then 3 to 7 for Sa4 to Sa8.
- R5: A strobed frame with `frm_mf_first`=1 closes the multiframe. If eight align and eight non-align samples were taken since the previous boundary, all eight host registers update at that clock edge and `mf_ready` is high for exactly the following cycle.
- R6: Between publishes the host registers hold their values, so a read during collection returns the last complete multiframe.
- R7: If fewer than eight align samples or fewer than eight non-align samples were taken when a boundary arrives, the partial data is discarded. No ready pulse is raised and the host registers keep their previous values.
- R8: Frames before the first boundary after reset are not counted, so the first boundary never publishes.
- R9: The boundary frame itself supplies the first sample of the new multiframe and ends up in the MSB of the registers it feeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe: `ts0_in` holds a frame's timeslot-0 bits |
| frm_align | input | 1 | 1 = the strobed frame is an align frame |
| frm_mf_first | input | 1 | 1 = the strobed frame is the first of a multiframe |
| ts0_in | input | 8 | Timeslot-0 bits, bit 7 received first |
| rd_idx | input | 3 | Host register select (0 to 7) |
| rd_data | output | 8 | Selected host register |
| mf_ready | output | 1 | One-cycle pulse after a publish |

## Verification
A bit that a lane samples from the wrong frame type or from the wrong position changes that register's byte. The error is visible at `rd_data` as soon as the next boundary publishes, one cycle after the boundary strobe. A sample counter that is wrong shows up at the first short or long multiframe, either as a missing `mf_ready` pulse or as a spurious one. A copy that leaks outside a publish changes the snapshot when it is read in the middle of the next multiframe.

// File: rtl/mfoh_pkg.sv
package mfoh_pkg;

    localparam int LANES   = 8;
    localparam int TS0_W   = 8;
    localparam int IDX_W   = $clog2(LANES);

    typedef enum logic [IDX_W-1:0] {
        LANE_SI_AL = 3'd0,
        LANE_SI_NA = 3'd1,
        LANE_RA    = 3'd2,
        LANE_SA4   = 3'd3,
        LANE_SA5   = 3'd4,
        LANE_SA6   = 3'd5,
        LANE_SA7   = 3'd6,
        LANE_SA8   = 3'd7
    } lane_e;

    typedef struct packed {
        logic              strobe;
        logic              align;
        logic              mf_first;
        logic [TS0_W-1:0]  ts0;
    } frame_t;

    typedef struct packed {
        logic take_al;
        logic take_na;
        logic restart;
        logic publish;
    } ctl_t;

    // timeslot-0 bit position feeding a lane
    function automatic int lane_bit(input int idx);
        return (idx < int'(LANE_RA)) ? TS0_W - 1 : TS0_W - 1 - idx;
    endfunction

    // only the Si-align lane listens to align frames
    function automatic bit lane_on_align(input int idx);
        return idx == int'(LANE_SI_AL);
    endfunction

endpackage

// File: rtl/mfoh_tracker.sv
module mfoh_tracker
    import mfoh_pkg::*;
#(
    parameter int SAMPLES = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  frame_t frm,
    output ctl_t   ctl
);
    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] FULL = CW'(SAMPLES);

    logic [CW-1:0] cnt_al, cnt_na;
    logic          armed_q;
    logic          live;

    assign live = frm.strobe && (armed_q || frm.mf_first);

    always_comb begin
        ctl.take_al = live && frm.align;
        ctl.take_na = live && !frm.align;
        ctl.restart = frm.strobe && frm.mf_first;
        ctl.publish = ctl.restart && armed_q && (cnt_al == FULL) && (cnt_na == FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_al  <= '0;
            cnt_na  <= '0;
        end else if (ctl.restart) begin
            armed_q <= 1'b1;
            cnt_al  <= ctl.take_al ? CW'(1) : '0;
            cnt_na  <= ctl.take_na ? CW'(1) : '0;
        end else begin
            if (ctl.take_al && cnt_al != FULL) cnt_al <= cnt_al + 1'b1;
            if (ctl.take_na && cnt_na != FULL) cnt_na <= cnt_na + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_al <= FULL) && (cnt_na <= FULL)); // R7

    AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> (cnt_al == '0) && (cnt_na == '0)); // R8

endmodule

// File: rtl/mfoh_lane.sv
module mfoh_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic         bit_in,
    input  logic         restart,
    input  logic         publish,
    output logic [W-1:0] host
);
    logic [W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            host  <= '0;
        end else begin
            if (publish) host <= stage;
            if (restart)   stage <= take ? W'(bit_in) : '0;
            else if (take) stage <= {stage[W-2:0], bit_in};
        end
    end

    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !publish |=> $stable(host)); // R6

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (restart && !take) |=> (stage == '0)); // R9

endmodule

// File: rtl/mfoh_collector.sv
module mfoh_collector
    import mfoh_pkg::*;
#(
    parameter int SAMPLES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frm_stb,
    input  logic               frm_align,
    input  logic               frm_mf_first,
    input  logic [TS0_W-1:0]   ts0_in,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [SAMPLES-1:0] rd_data,
    output logic               mf_ready
);
    frame_t frm;
    ctl_t   ctl;
    logic [SAMPLES-1:0] host [LANES];

    assign frm = '{strobe: frm_stb, align: frm_align, mf_first: frm_mf_first, ts0: ts0_in};

    mfoh_tracker #(.SAMPLES(SAMPLES)) tracker_i (
        .clk (clk),
        .rst (rst),
        .frm (frm),
        .ctl (ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int  POS    = lane_bit(g);
        localparam bit  ON_AL  = lane_on_align(g);
        mfoh_lane #(.W(SAMPLES)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .take    (ON_AL ? ctl.take_al : ctl.take_na),
            .bit_in  (frm.ts0[POS]),
            .restart (ctl.restart),
            .publish (ctl.publish),
            .host    (host[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) mf_ready <= 1'b0;
        else     mf_ready <= ctl.publish;
    end

    assign rd_data = host[rd_idx];

    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        mf_ready |-> $past(frm_stb && frm_mf_first)); // R5

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mf_ready |=> !mf_ready); // R5

endmodule

// File: tb/mfoh_collector_tb_top.sv
`timescale 1ns/1ps
module mfoh_collector_tb_top;
    localparam int W = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic frm_stb = 1'b0, frm_align = 1'b0, frm_mf_first = 1'b0;
    logic [7:0] ts0_in = '0;
    logic [2:0] rd_idx = '0;
    logic [W-1:0] rd_data;
    logic mf_ready;

    int checks = 0, fails = 0, pulses = 0, cyc = 0;

    always #2.5 clk = ~clk;

    mfoh_collector #(.SAMPLES(W)) dut_i (
        .clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_align(frm_align),
        .frm_mf_first(frm_mf_first), .ts0_in(ts0_in), .rd_idx(rd_idx),
        .rd_data(rd_data), .mf_ready(mf_ready)
    );

    // stimulus table: one seed per multiframe
    localparam logic [31:0] VEC_SEED [5] = '{
        32'hA5C3_1E97, 32'h0F0F_F0F0, 32'hFFFF_0000, 32'h1234_5678, 32'h6B2D_E14C
    };

    logic [7:0] fb [16];
    logic       fa [16];
    logic [7:0] cur_exp [8];
    logic [7:0] pending [8];
    logic [7:0] pub [8];

    always @(negedge clk) if (mf_ready) pulses++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // positions per requirement R2/R3 (bench's own table)
    function automatic int src_pos(input int l);
        case (l)
            0, 1:    return 7;
            2:       return 5;
            3:       return 4;
            4:       return 3;
            5:       return 2;
            6:       return 1;
            default: return 0;
        endcase
    endfunction

    task automatic build(input logic [31:0] seed);
        for (int f = 0; f < 16; f++) begin
            fa[f] = (f % 2 == 0);
            fb[f] = seed[8*(f%4) +: 8] ^ 8'(f * 29);
        end
        for (int l = 0; l < 8; l++) begin
            logic [7:0] e = '0;
            for (int f = 0; f < 16; f++)
                if ((l == 0) == fa[f]) e = {e[6:0], fb[f][src_pos(l)]};
            cur_exp[l] = e;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic al, input logic mf);
        frm_stb = 1'b1; frm_align = al; frm_mf_first = mf; ts0_in = b;
        @(negedge clk);
        frm_stb = 1'b0; frm_mf_first = 1'b0;
        #0.1;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.1;
            chk({req, "/R4 idx ", $sformatf("%0d", i)}, 32'(rd_data), 32'(pub[i]));
        end
    endtask

    // one full multiframe; its first frame is a boundary
    task automatic run_vector(input logic [31:0] seed, input bit expect_pub, input string req);
        int p0;
        build(seed);
        for (int f = 0; f < 16; f++) begin
            p0 = pulses;
            send(fb[f], fa[f], f == 0);
            if (f == 0) begin
                chk({req, " pulse"}, 32'(pulses - p0), expect_pub ? 1 : 0);
                if (expect_pub) for (int l = 0; l < 8; l++) pub[l] = pending[l];
                check_regs(req);
            end
            if (f == 1) chk("R5 single pulse", 32'(mf_ready), 0);
            if (f == 8) check_regs("R6 mid-collection");
        end
        for (int l = 0; l < 8; l++) pending[l] = cur_exp[l];
    endtask

    initial begin
        int p0;
        for (int l = 0; l < 8; l++) pub[l] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.1;
        chk("R1 ready", 32'(mf_ready), 0);
        check_regs("R1");

        // frames before any boundary: must not count (R8)
        for (int f = 0; f < 24; f++) send(8'(f * 53 + 7), f % 2 == 0, 1'b0);

        // table walk: first boundary does not publish (R8), later ones do (R2, R3, R5)
        for (int v = 0; v < 4; v++)
            run_vector(VEC_SEED[v], v != 0, v == 0 ? "R8" : "R5/R2/R3");

        // short multiframe: boundary publishes last full vector, then discard (R7)
        p0 = pulses;
        send(8'hC6, 1'b1, 1'b1);
        chk("R5 pulse", 32'(pulses - p0), 1);
        for (int l = 0; l < 8; l++) pub[l] = pending[l];
        check_regs("R5/R2/R3");
        for (int f = 1; f < 10; f++) send(8'(f * 71), f % 2 == 0, 1'b0);
        p0 = pulses;
        send(8'hFF, 1'b1, 1'b1);
        chk("R7 short no pulse", 32'(pulses - p0), 0);
        check_regs("R7 short");

        // align-only multiframe: non-align lanes starved (R7)
        for (int f = 1; f < 16; f++) send(8'(f * 17 + 3), 1'b1, 1'b0);
        run_vector(VEC_SEED[4], 1'b0, "R7 starved");

        // recovery: boundary frame contributes the MSB of the new data (R9)
        run_vector(VEC_SEED[1], 1'b1, "R9");
        p0 = pulses;
        send(8'h00, 1'b1, 1'b1);
        for (int l = 0; l < 8; l++) pub[l] = pending[l];
        chk("R9 pulse", 32'(pulses - p0), 1);
        check_regs("R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule